// File: doc/BRIEF.md
# Local Bus Cycle Sequencer

This block turns a request for a run of 32-bit words into data cycles on a local bus. A host-side slave puts in the request. The sequencer opens each run with an address phase, then steps through data phases until every word has moved. A configured width code sets the local data width. For 8-bit and 16-bit buses each word is cut into narrow beats, and the narrow data always travels on the low byte lanes.

Three kinds of timing control shape the run:
- A 4-bit count puts idle cycles between consecutive data phases.
- An optional READY handshake stretches each data phase until the target is ready.
- Burst controls decide when a fresh address phase is needed. Bursting can be switched off, which gives one address phase per word. Without the burst-terminate input, a burst is capped at four words. With that input enabled, the target can end a burst early, and the cap no longer applies.

Read words are returned with a valid pulse. Write words are taken from the host one at a time, and a take pulse asks for the next word. A one-cycle done pulse marks the end of the request.

Top module: `lbus_cycle_seq`

## Requirements
- R1: Width code 00 gives 1-byte beats, four per word, with byte enables 0001. Code 01 gives 2-byte beats, two per word, with enables 0011. Codes 10 and 11 give one 4-byte beat per word, with enables 1111. Beat k of a word carries word bytes starting at byte k times the beat size, little-endian, on the lowest lanes.
- R2: An address phase (lb_ads high for one cycle) always presents the current address, and the first data phase follows it directly. The address starts at req_addr, which is word aligned, and advances by the beat size after every completed beat. lb_ads and lb_ds are never high together.
- R3: After every completed beat except the last one, exactly cfg_waits idle cycles (0 to 15) come before the next address or data phase. With READY off, the cycles from the accepting clock edge to the edge that raises done number A + B + W*(B-1). Here A is the number of address phases, B the number of beats and W the wait count.
- R4: When cfg_rdy_en is 1, a data phase holds its address and data until lb_ready is sampled high. When cfg_rdy_en is 0, lb_ready has no effect on timing.
- R5: When cfg_burst_en is 0, every word gets its own address phase.
- R6: When cfg_bterm_en is 0, a burst carries at most four words before a new address phase, and lb_bterm has no effect.
- R7: When cfg_bterm_en is 1, lb_bterm sampled high on any completed beat ends the burst. The next word then starts with a new address phase, even if the beat was in the middle of a word, and no four-word cap applies. lb_bterm on the final beat adds no address phase.
- R8: done is high for exactly one cycle, in the cycle after the final beat completes. busy is high from the cycle after acceptance up to that point. req_valid is accepted only while the sequencer is idle and is ignored while busy.
- R9: For reads, rd_valid pulses for one cycle after the last beat of each word, and rd_data holds the assembled word.
- R10: For writes, wr_data is sampled at the accepting edge and at the last beat of each word except the final one. wr_take pulses in the cycle after each such sample.
- R11: Reset, whether at start-up or in mid-transfer, leaves the sequencer idle with lb_ads, lb_ds, lb_be, busy and done all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transfer (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word-aligned start address |
| req_words | input | CNT_W | Number of 32-bit words, at least 1 |
| wr_data | input | DATA_W | Current write word from the host |
| cfg_width | input | 2 | Local width code |
| cfg_waits | input | WAIT_W | Idle cycles between data phases |
| cfg_rdy_en | input | 1 | Honour lb_ready |
| cfg_burst_en | input | 1 | Allow multi-word bursts |
| cfg_bterm_en | input | 1 | Honour lb_bterm, lift four-word cap |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| wr_take | output | 1 | Write word consumed, present the next |
| rd_valid | output | 1 | rd_data holds a completed read word |
| rd_data | output | DATA_W | Assembled read word |
| lb_ads | output | 1 | Address phase strobe |
| lb_ds | output | 1 | Data phase strobe |
| lb_wr | output | 1 | Direction of the current transfer |
| lb_addr | output | ADDR_W | Local address |
| lb_be | output | DATA_W/8 | Byte lane enables |
| lb_wdata | output | DATA_W | Write data lanes |
| lb_rdata | input | DATA_W | Read data lanes |
| lb_ready | input | 1 | Target ready |
| lb_bterm | input | 1 | Target burst terminate |

## Verification
Two burst-ending causes can land on the same word boundary in one cycle: the target's terminate input and the end of the request. They are provoked in two ways. The first holds terminate high through a three-word run. The second pulses terminate in the middle of a word on the 8-bit bus, so the restart has to be carried over to the next word boundary. Each case is judged by the number of address phases, the address on each phase, and the done latency computed from the A + B + W*(B-1) formula. A further run pulses a second request during long waits to check that a busy sequencer ignores it.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_WAIT
   } lbs_state_t;

   // bytes moved per local beat for a width code
   function automatic logic [2:0] beat_bytes(input logic [1:0] code);
      case (code)
         2'b00:   return 3'd1;
         2'b01:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   // local beats needed to move one 32-bit word
   function automatic logic [2:0] beats_per_word(input logic [1:0] code);
      case (code)
         2'b00:   return 3'd4;
         2'b01:   return 3'd2;
         default: return 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
   parameter int unsigned WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] load_val,
   output logic              last,
   output logic              running
);

   logic [WAIT_W-1:0] cnt_q;

   initial begin
      assert (WAIT_W >= 1 && WAIT_W <= 16)
         else $error("lbs_wait_timer: WAIT_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last    = (cnt_q == WAIT_W'(1));
   assign running = (cnt_q != '0);

   // R3: a running countdown is never reloaded before it ends
   p_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      running && !last |-> !load);

endmodule

// File: rtl/lbs_burst_track.sv
module lbs_burst_track #(
   parameter int unsigned MAX_BURST = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic beat_done,
   input  logic word_done,
   input  logic bterm_in,
   input  logic bterm_en,
   input  logic burst_en,
   output logic need_new
);

   localparam int unsigned BW = $clog2(MAX_BURST + 1);

   logic [BW-1:0] words_q;
   logic          pend_q;
   logic          bterm_hit;
   logic          cap_hit;

   initial begin
      assert (MAX_BURST >= 1)
         else $error("lbs_burst_track: MAX_BURST must be at least 1");
   end

   assign bterm_hit = beat_done && bterm_en && bterm_in;

   generate
      if (MAX_BURST == 1) begin : g_single
         assign cap_hit = !bterm_en;
      end else begin : g_multi
         assign cap_hit = !bterm_en && (words_q + BW'(1) == BW'(MAX_BURST));
      end
   endgenerate

   assign need_new = !burst_en || pend_q || bterm_hit || cap_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words_q <= '0;
         pend_q  <= 1'b0;
      end else if (start) begin
         words_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (bterm_hit)
            pend_q <= 1'b1;
         if (word_done && words_q != BW'(MAX_BURST))
            words_q <= words_q + 1'b1;
      end
   end

   // R6: without the terminate input a burst never exceeds the cap
   p_burst_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bterm_en |-> words_q <= BW'(MAX_BURST));

   // R7: a pending terminate is cleared only by a new address phase
   p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !start |=> pend_q);

endmodule

// File: rtl/lbs_lane_map.sv
module lbs_lane_map #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                 strobe,
   input  logic [1:0]           width_code,
   input  logic [OFF_W-1:0]     byte_off,
   input  logic [DATA_W-1:0]    word_in,
   input  logic [DATA_W-1:0]    rd_acc,
   input  logic [DATA_W-1:0]    bus_rdata,
   output logic [LANES-1:0]     be,
   output logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    rd_merged
);

   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned OFF_W = $clog2(LANES);

   logic [OFF_W:0] bsz;

   assign bsz       = (OFF_W + 1)'(lbs_pkg::beat_bytes(width_code));
   assign bus_wdata = word_in >> {byte_off, 3'b000};

   genvar j;
   generate
      for (j = 0; j < LANES; j++) begin : g_lane
         localparam logic [OFF_W:0] IDX = (OFF_W + 1)'(j);
         logic [OFF_W:0]  rel;
         logic            in_win;
         logic [DATA_W-1:0] shifted;

         assign be[j]   = strobe && (IDX < bsz);
         assign rel     = IDX - {1'b0, byte_off};
         assign in_win  = (IDX >= {1'b0, byte_off}) && (rel < bsz);
         assign shifted = bus_rdata >> {rel[OFF_W-1:0], 3'b000};
         assign rd_merged[8*j +: 8] = in_win ? shifted[7:0] : rd_acc[8*j +: 8];
      end
   endgenerate

endmodule

// File: rtl/lbus_cycle_seq.sv
module lbus_cycle_seq #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned WAIT_W    = 4,
   parameter int unsigned MAX_BURST = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [CNT_W-1:0]    req_words,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [1:0]          cfg_width,
   input  logic [WAIT_W-1:0]   cfg_waits,
   input  logic                cfg_rdy_en,
   input  logic                cfg_burst_en,
   input  logic                cfg_bterm_en,
   output logic                busy,
   output logic                done,
   output logic                wr_take,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   output logic                lb_ads,
   output logic                lb_ds,
   output logic                lb_wr,
   output logic [ADDR_W-1:0]   lb_addr,
   output logic [DATA_W/8-1:0] lb_be,
   output logic [DATA_W-1:0]   lb_wdata,
   input  logic [DATA_W-1:0]   lb_rdata,
   input  logic                lb_ready,
   input  logic                lb_bterm
);

   import lbs_pkg::*;

   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned OFF_W = $clog2(LANES);

   initial begin
      assert (DATA_W == 32)
         else $error("lbus_cycle_seq: width codes are defined for 32-bit words");
      assert (ADDR_W >= 8)
         else $error("lbus_cycle_seq: ADDR_W too small");
      assert (CNT_W >= 1)
         else $error("lbus_cycle_seq: CNT_W must be at least 1");
   end

   lbs_state_t        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  words_left_q;
   logic [OFF_W-1:0]  beat_q;
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] rd_acc_q;
   logic [DATA_W-1:0] rd_q;
   logic [1:0]        width_q;
   logic [WAIT_W-1:0] waits_q;
   logic              wr_q, rdy_en_q, burst_en_q, bterm_en_q;
   logic              addr_pend_q;
   logic              done_q, rdv_q, take_q;

   logic [OFF_W:0]    bsz;
   logic [OFF_W:0]    bpw;
   logic [OFF_W-1:0]  byte_off;
   logic              beat_done, last_beat, last_word, word_done, final_beat;
   logic              need_new, next_new;
   logic              t_load, t_last, t_running;
   logic [DATA_W-1:0] rd_merged;

   assign bsz        = (OFF_W + 1)'(beat_bytes(width_q));
   assign bpw        = (OFF_W + 1)'(beats_per_word(width_q));
   assign byte_off   = OFF_W'(beat_q * bsz[OFF_W-1:0]);
   assign beat_done  = (state_q == ST_DATA) && (!rdy_en_q || lb_ready);
   assign last_beat  = ({1'b0, beat_q} == bpw - 1'b1);
   assign last_word  = (words_left_q == CNT_W'(1));
   assign word_done  = beat_done && last_beat;
   assign final_beat = word_done && last_word;
   assign next_new   = word_done && need_new;
   assign t_load     = beat_done && !final_beat && (waits_q != '0);

   lbs_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (waits_q),
      .last     (t_last),
      .running  (t_running)
   );

   lbs_burst_track #(.MAX_BURST(MAX_BURST)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (state_q == ST_ADDR),
      .beat_done (beat_done),
      .word_done (word_done),
      .bterm_in  (lb_bterm),
      .bterm_en  (bterm_en_q),
      .burst_en  (burst_en_q),
      .need_new  (need_new)
   );

   lbs_lane_map #(.DATA_W(DATA_W)) u_lanes (
      .strobe     (state_q == ST_DATA),
      .width_code (width_q),
      .byte_off   (byte_off),
      .word_in    (word_q),
      .rd_acc     (rd_acc_q),
      .bus_rdata  (lb_rdata),
      .be         (lb_be),
      .bus_wdata  (lb_wdata),
      .rd_merged  (rd_merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         addr_q       <= '0;
         words_left_q <= '0;
         beat_q       <= '0;
         word_q       <= '0;
         rd_acc_q     <= '0;
         rd_q         <= '0;
         width_q      <= 2'b10;
         waits_q      <= '0;
         wr_q         <= 1'b0;
         rdy_en_q     <= 1'b0;
         burst_en_q   <= 1'b0;
         bterm_en_q   <= 1'b0;
         addr_pend_q  <= 1'b0;
         done_q       <= 1'b0;
         rdv_q        <= 1'b0;
         take_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         rdv_q  <= 1'b0;
         take_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q       <= req_addr;
                  words_left_q <= req_words;
                  width_q      <= cfg_width;
                  waits_q      <= cfg_waits;
                  wr_q         <= req_write;
                  rdy_en_q     <= cfg_rdy_en;
                  burst_en_q   <= cfg_burst_en;
                  bterm_en_q   <= cfg_bterm_en;
                  beat_q       <= '0;
                  word_q       <= wr_data;
                  take_q       <= req_write;
                  state_q      <= ST_ADDR;
               end
            end
            ST_ADDR: state_q <= ST_DATA;
            ST_DATA: begin
               if (beat_done) begin
                  addr_q   <= addr_q + ADDR_W'(bsz);
                  rd_acc_q <= rd_merged;
                  beat_q   <= last_beat ? '0 : beat_q + 1'b1;
                  if (word_done) begin
                     words_left_q <= words_left_q - 1'b1;
                     rd_q         <= rd_merged;
                     rdv_q        <= !wr_q;
                     if (wr_q && !last_word) begin
                        word_q <= wr_data;
                        take_q <= 1'b1;
                     end
                  end
                  if (final_beat) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (waits_q != '0) begin
                     addr_pend_q <= next_new;
                     state_q     <= ST_WAIT;
                  end else begin
                     state_q <= next_new ? ST_ADDR : ST_DATA;
                  end
               end
            end
            ST_WAIT: begin
               if (t_last)
                  state_q <= addr_pend_q ? ST_ADDR : ST_DATA;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign wr_take  = take_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rd_q;
   assign lb_ads   = (state_q == ST_ADDR);
   assign lb_ds    = (state_q == ST_DATA);
   assign lb_wr    = wr_q;
   assign lb_addr  = addr_q;

   // R2: address and data strobes never overlap
   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(lb_ads && lb_ds));
   // R2: an address phase is followed at once by a data phase
   p_ads_then_ds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lb_ads |=> lb_ds);
   // R2: address moves by the beat size after each completed beat
   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      beat_done && !final_beat |=> lb_addr == $past(lb_addr) + ADDR_W'($past(bsz)));
   // R1: byte enables follow one of the three legal lane patterns
   p_be_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lb_ds |-> (lb_be == 4'b0001 || lb_be == 4'b0011 || lb_be == 4'b1111));
   // R4: a stalled data phase holds its strobe and address
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lb_ds && rdy_en_q && !lb_ready |=> lb_ds && $stable(lb_addr));
   // R3: the wait state is always backed by a running countdown
   p_wait_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> t_running);
   // R8: done lasts one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11: an idle sequencer drives no strobes
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !lb_ads && !lb_ds && lb_be == '0);

endmodule

// File: tb/lbus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module lbus_cycle_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  req_words = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  cfg_width = 2'b10;
   logic [3:0]  cfg_waits = '0;
   logic        cfg_rdy_en = 1'b0, cfg_burst_en = 1'b1, cfg_bterm_en = 1'b0;
   logic        busy, done, wr_take, rd_valid;
   logic [31:0] rd_data;
   logic        lb_ads, lb_ds, lb_wr;
   logic [31:0] lb_addr;
   logic [3:0]  lb_be;
   logic [31:0] lb_wdata, lb_rdata;
   logic        lb_ready = 1'b0, lb_bterm = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   lbus_cycle_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_words(req_words), .wr_data(wr_data),
      .cfg_width(cfg_width), .cfg_waits(cfg_waits), .cfg_rdy_en(cfg_rdy_en),
      .cfg_burst_en(cfg_burst_en), .cfg_bterm_en(cfg_bterm_en),
      .busy(busy), .done(done), .wr_take(wr_take), .rd_valid(rd_valid),
      .rd_data(rd_data), .lb_ads(lb_ads), .lb_ds(lb_ds), .lb_wr(lb_wr),
      .lb_addr(lb_addr), .lb_be(lb_be), .lb_wdata(lb_wdata),
      .lb_rdata(lb_rdata), .lb_ready(lb_ready), .lb_bterm(lb_bterm)
   );

   typedef struct {
      int ads;
      int beats;
      int lat;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] rd_q[$];

   int n_cmp = 0, n_bad = 0;
   int lat = 0, ads_n = 0, beats = 0, stall = 0, widx = 0;
   int bterm_at = -1;
   bit act = 0, done_seen = 0, stall_mode = 0, rdy_level = 0, bterm_always = 0;

   function automatic logic [7:0] mb(input logic [31:0] a);
      return a[7:0] ^ 8'h5A;
   endfunction

   function automatic logic [31:0] wpat(input int n);
      return 32'h11223344 + 32'(n) * 32'h01010101;
   endfunction

   function automatic int bsz_of(input logic [1:0] c);
      return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
   endfunction

   assign lb_rdata = {mb(lb_addr + 32'd3), mb(lb_addr + 32'd2),
                      mb(lb_addr + 32'd1), mb(lb_addr)};

   task automatic check(input bit ok, input string req, input longint act_v, input longint exp_v);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
      end
   endtask

   // monitor: drives target responses and compares against the scoreboard
   always @(negedge clk) begin
      if (rst_n && act) begin
         bit          rdy, cmpl;
         int          bs;
         int          n, k0;
         logic [31:0] ea;
         lat++;
         bs = bsz_of(cfg_width);
         ea = req_addr + 32'(beats * bs);
         if (lb_ads) begin
            ads_n++;
            check(lb_addr == ea, "R2 ads addr", lb_addr, ea);
         end
         if (lb_ds) begin
            rdy      = stall_mode ? (stall >= 2) : rdy_level;
            lb_ready = rdy;
            lb_bterm = bterm_always || (beats == bterm_at);
            cmpl     = rdy || !cfg_rdy_en;
            if (cmpl) begin
               logic [3:0] ebe;
               ebe = (bs == 1) ? 4'b0001 : (bs == 2) ? 4'b0011 : 4'b1111;
               check(lb_addr == ea, "R2 beat addr", lb_addr, ea);
               check(lb_be == ebe, "R1 byte enables", lb_be, ebe);
               if (req_write) begin
                  n  = beats / (4 / bs);
                  k0 = (beats % (4 / bs)) * bs;
                  for (int j = 0; j < bs; j++) begin
                     logic [7:0] eb;
                     eb = 8'(wpat(n) >> (8 * (k0 + j)));
                     check(lb_wdata[8*j +: 8] == eb, "R10 write lane", lb_wdata[8*j +: 8], eb);
                  end
               end
               beats++;
               stall = 0;
            end else begin
               stall++;
            end
         end else begin
            lb_ready = stall_mode ? 1'b0 : rdy_level;
            lb_bterm = bterm_always;
         end
         if (wr_take) begin
            widx++;
            wr_data = wpat(widx);
         end
         if (rd_valid) begin
            logic [31:0] er;
            if (rd_q.size() == 0) check(0, "R9 unexpected rd_valid", rd_data, 0);
            else begin
               er = rd_q.pop_front();
               check(rd_data == er, "R9 read word", rd_data, er);
            end
         end
         if (done) begin
            exp_t e;
            e = exp_q.pop_front();
            check(ads_n == e.ads, "R5/R6/R7 address phases", ads_n, e.ads);
            check(beats == e.beats, "R1 beat count", beats, e.beats);
            check(lat == e.lat + 1, "R3/R8 done latency", lat - 1, e.lat);
            check(rd_q.size() == 0, "R9 missing reads", rd_q.size(), 0);
            act = 0;
            done_seen = 1;
         end
      end
   end

   // driver: pushes expectations then issues the request
   task automatic run(input bit wr, input logic [1:0] wc, input int waits, input int words,
                      input bit burst, input bit bten, input bit rdyen,
                      input int e_ads, input int e_beats, input int e_lat, input bit poke);
      exp_t e;
      int   t;
      @(negedge clk);
      #1;
      req_write = wr; cfg_width = wc; cfg_waits = 4'(waits); req_words = 8'(words);
      cfg_burst_en = burst; cfg_bterm_en = bten; cfg_rdy_en = rdyen;
      req_addr = req_addr + 32'h100;
      e.ads = e_ads; e.beats = e_beats; e.lat = e_lat;
      exp_q.push_back(e);
      if (!wr)
         for (int n = 0; n < words; n++)
            rd_q.push_back({mb(req_addr + 32'(4*n+3)), mb(req_addr + 32'(4*n+2)),
                            mb(req_addr + 32'(4*n+1)), mb(req_addr + 32'(4*n))});
      widx = 0; wr_data = wpat(0);
      lat = 0; ads_n = 0; beats = 0; stall = 0; done_seen = 0; act = 1;
      req_valid = 1'b1;
      @(negedge clk);
      #1 req_valid = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         #1 req_valid = 1'b1;   // R8: must be ignored while busy
         @(negedge clk);
         #1 req_valid = 1'b0;
      end
      t = 0;
      while (!done_seen && t < 3000) begin
         @(negedge clk);
         t++;
      end
      if (!done_seen) begin
         check(0, "R8 watchdog", t, 0);
         act = 0; exp_q.delete(); rd_q.delete();
      end
      repeat (3) begin
         @(negedge clk);
         check(!lb_ads && !lb_ds && !done && !busy, "R8 idle after done",
               {lb_ads, lb_ds, done, busy}, 0);
      end
      stall_mode = 0; rdy_level = 0; bterm_always = 0; bterm_at = -1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!lb_ads && !lb_ds && !busy && !done && lb_be == 0, "R11 reset state",
            {lb_ads, lb_ds, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // widths (R1), plain burst
      run(0, 2'b10, 0, 3, 1, 0, 0, 1, 3, 4, 0);
      run(0, 2'b01, 0, 2, 1, 0, 0, 1, 4, 5, 0);
      run(0, 2'b00, 0, 2, 1, 0, 0, 1, 8, 9, 0);
      run(1, 2'b11, 0, 1, 1, 0, 0, 1, 1, 2, 0);
      run(1, 2'b00, 0, 2, 1, 0, 0, 1, 8, 9, 0);
      // waits 15 (R3), with ignored request mid-run (R8)
      run(0, 2'b10, 15, 3, 1, 0, 0, 1, 3, 34, 1);
      run(1, 2'b00, 15, 1, 1, 0, 0, 1, 4, 50, 0);
      // R6: four-word cap, terminate ignored
      bterm_always = 1;
      run(1, 2'b10, 0, 9, 1, 0, 0, 3, 9, 12, 0);
      // R7: no cap when terminate input enabled
      run(0, 2'b10, 0, 9, 1, 1, 0, 1, 9, 10, 0);
      // R7: terminate on second beat
      bterm_at = 1;
      run(0, 2'b10, 0, 6, 1, 1, 0, 2, 6, 8, 0);
      // R7: terminate mid-word on 8-bit bus
      bterm_at = 1;
      run(1, 2'b00, 0, 2, 1, 1, 0, 2, 8, 10, 0);
      // R7: terminate held, final beat adds nothing
      bterm_always = 1;
      run(0, 2'b10, 0, 3, 1, 1, 0, 3, 3, 6, 0);
      // R5: bursting off, 16-bit, waits 2
      run(1, 2'b01, 2, 3, 0, 0, 0, 3, 6, 19, 0);
      // R4: READY honoured with two stall cycles per beat
      stall_mode = 1;
      run(0, 2'b10, 1, 2, 1, 0, 1, 1, 2, 8, 0);
      // R4: READY ignored when disabled
      rdy_level = 0;
      run(0, 2'b10, 0, 2, 1, 0, 0, 1, 2, 3, 0);

      // R11: reset in mid-transfer
      @(negedge clk);
      #1;
      cfg_waits = 4'd15; req_words = 8'd4; req_write = 1'b0; cfg_width = 2'b00;
      req_valid = 1'b1;
      @(negedge clk);
      #1 req_valid = 1'b0;
      repeat (6) @(negedge clk);
      check(busy, "R11 busy before reset", busy, 1);
      rst_n = 1'b0;
      @(negedge clk);
      check(!lb_ads && !lb_ds && !busy && !done && lb_be == 0, "R11 reset mid-transfer",
            {lb_ads, lb_ds, busy, done}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!lb_ads && !lb_ds && !busy, "R11 stays idle", {lb_ads, lb_ds, busy}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1600000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule